// File: doc/BRIEF.md
# Halt and Soft-Mute Controller

This block lets a DSP core be taken down and brought back without an audible click while its data source or its master clock is being reconfigured. Setting a halt bit in the first control register starts a gain ramp toward zero, one fixed step per sample-rate tick. When the gain reaches zero, the core-run enable drops and a readable "stopped" status bit rises. Clearing the halt bit re-enables the core at once. The gain then climbs back by the same step to unity, and only then does the block report normal operation. If the halt bit changes while a ramp is in progress, the ramp reverses where it stands.

A separate soft power-down bit in the same register gates the internal core clock. A clock-mode bit in the second control register picks direct 512x operation (0) or doubled 256x operation (1). That bit can be written only while the clock is gated or the core is stopped; any other write to it is dropped. The clock doubler itself lies outside this block.

Top module: `halt_mute_ctrl`

## Requirements
- R1: After reset, `gain` equals unity (2^(GAIN_W-1), 32768 by default), `core_run` is 1, `run_ok` is 1, `clk_gate_en` is 1, `clk_mode` is 0, and `cr1_rdata` reads 0.
- R2: Writing `cr1_wdata` bit 0 = 1 requests a halt. From the cycle after the request is seen, each `fs_tick` lowers `gain` by STEP (4096 by default), saturating at 0.
- R3: In the cycle after the gain reaches 0 during a halt, `core_run` falls to 0 and the stopped status (`cr1_rdata` bit 1) reads 1. Both stay that way, with `gain` at 0, while the halt bit remains 1.
- R4: Clearing the halt bit makes `core_run` 1 in the next cycle. `gain` then rises by STEP per `fs_tick`, saturating at unity.
- R5: Clearing the halt bit during the ramp down reverses the ramp upward. Setting it during the ramp up reverses the ramp downward. Each reversal starts from the current gain.
- R6: `gain` never changes on a clock edge at which `fs_tick` is 0.
- R7: Once a halt is seen, the stopped status rises within ceil(unity/STEP)+2 `fs_tick` pulses (10 by default). MAX_STOP_TICKS (960 ticks, which is 20 ms at 48 kHz) must be at least that bound.
- R8: `cr1_wdata` bit 6 is soft power-down. In the cycle after it is written as 1, `clk_gate_en` is 0; in the cycle after it is written as 0, `clk_gate_en` is 1. The bit reads back at `cr1_rdata` bit 6, and the halt bit reads back at bit 0.
- R9: `cr2_wdata` bit 2 sets the clock mode (0 = direct 512x, 1 = doubled 256x), shown on `clk_mode` and `cr2_rdata` bit 2. A write is taken only when soft power-down is 1 or the core is stopped; otherwise it is ignored.
- R10: `run_ok` is 1 only in normal operation, which is reached when a rising ramp hits unity. `run_ok` implies `gain` is unity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_tick | input | 1 | One-cycle sample-rate strobe that paces the ramps |
| cr1_we | input | 1 | Write strobe for control register 1 |
| cr1_wdata | input | REG_W | Control register 1 write data: halt at bit 0, power-down at bit 6 |
| cr2_we | input | 1 | Write strobe for control register 2 |
| cr2_wdata | input | REG_W | Control register 2 write data: clock mode at bit 2 |
| cr1_rdata | output | REG_W | Readback: halt bit 0, stopped status bit 1, power-down bit 6 |
| cr2_rdata | output | REG_W | Readback: clock mode bit 2 |
| gain | output | GAIN_W | Gain to the datapath |
| core_run | output | 1 | Core run enable |
| run_ok | output | 1 | Normal operation reached |
| clk_gate_en | output | 1 | Internal clock enable, 0 while powered down |
| clk_mode | output | 1 | 0 = direct 512x, 1 = doubled 256x |

## Verification
A register write shows up at the readback and gate outputs one edge after its strobe. The first ramp step lags the halt write by one more edge, because the state machine has to leave its current state first. After that, gain moves on every clock edge that sees `fs_tick`. The stopped flag and `run_ok` change one edge after the gain reaches 0 or unity. The bench drives inputs on falling edges and runs each case for an exact number of tick edges. It samples on the following falling edge, and the expected gains are counted edge by edge with that one-edge lag included.

// File: rtl/hm_pkg.sv
package hm_pkg;
   typedef enum logic [1:0] {
      HM_RUN    = 2'd0,
      HM_FALL   = 2'd1,
      HM_HALTED = 2'd2,
      HM_RISE   = 2'd3
   } hm_state_e;

   localparam int HALT_BIT = 0;
   localparam int STAT_BIT = 1;
   localparam int PDN_BIT  = 6;
   localparam int MODE_BIT = 2;
endpackage

// File: rtl/hm_regs.sv
module hm_regs #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cr1_we,
   input  logic [REG_W-1:0] cr1_wdata,
   input  logic             cr2_we,
   input  logic [REG_W-1:0] cr2_wdata,
   input  logic             stopped,
   output logic             halt_req,
   output logic             pdn,
   output logic             mode,
   output logic [REG_W-1:0] cr1_rdata,
   output logic [REG_W-1:0] cr2_rdata
);
   import hm_pkg::*;

   logic mode_ok;
   assign mode_ok = pdn | stopped;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_req <= 1'b0;
         pdn      <= 1'b0;
      end else if (cr1_we) begin
         halt_req <= cr1_wdata[HALT_BIT];
         pdn      <= cr1_wdata[PDN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode <= 1'b0;
      else if (cr2_we && mode_ok)
         mode <= cr2_wdata[MODE_BIT];
   end

   always_comb begin
      cr1_rdata           = '0;
      cr1_rdata[HALT_BIT] = halt_req;
      cr1_rdata[STAT_BIT] = stopped;
      cr1_rdata[PDN_BIT]  = pdn;
      cr2_rdata           = '0;
      cr2_rdata[MODE_BIT] = mode;
   end
endmodule

// File: rtl/hm_ramp.sv
module hm_ramp #(
   parameter int GAIN_W = 16,
   parameter int STEP   = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_tick,
   input  logic              go_down,
   input  logic              go_up,
   output logic [GAIN_W-1:0] gain,
   output logic              at_zero,
   output logic              at_unity
);
   localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(1) << (GAIN_W - 1);
   localparam logic [GAIN_W-1:0] STEP_G  = GAIN_W'(STEP);
   localparam bit EXACT = ((1 << (GAIN_W - 1)) % STEP) == 0;

   logic [GAIN_W-1:0] dn_val, up_val;

   generate
      if (EXACT) begin : g_exact
         assign dn_val = gain - STEP_G;
         assign up_val = gain + STEP_G;
      end else begin : g_clamp
         assign dn_val = (gain > STEP_G) ? gain - STEP_G : '0;
         assign up_val = ((UNITY_G - gain) > STEP_G) ? gain + STEP_G : UNITY_G;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gain <= UNITY_G;
      else if (fs_tick) begin
         if (go_down && !at_zero)
            gain <= dn_val;
         else if (go_up && !at_unity)
            gain <= up_val;
      end
   end

   assign at_zero  = (gain == '0);
   assign at_unity = (gain == UNITY_G);
endmodule

// File: rtl/hm_seq.sv
module hm_seq (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            halt_req,
   input  logic            at_zero,
   input  logic            at_unity,
   output hm_pkg::hm_state_e st
);
   import hm_pkg::*;

   hm_state_e nxt;

   always_comb begin
      nxt = st;
      unique case (st)
         HM_RUN:    if (halt_req) nxt = HM_FALL;
         HM_FALL:   if (!halt_req) nxt = HM_RISE;
                    else if (at_zero) nxt = HM_HALTED;
         HM_HALTED: if (!halt_req) nxt = HM_RISE;
         HM_RISE:   if (halt_req) nxt = HM_FALL;
                    else if (at_unity) nxt = HM_RUN;
         default:   nxt = HM_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= HM_RUN;
      else        st <= nxt;
   end
endmodule

// File: rtl/halt_mute_ctrl.sv
module halt_mute_ctrl #(
   parameter int GAIN_W         = 16,
   parameter int STEP           = 4096,
   parameter int MAX_STOP_TICKS = 960,
   parameter int REG_W          = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fs_tick,
   input  logic              cr1_we,
   input  logic [REG_W-1:0]  cr1_wdata,
   input  logic              cr2_we,
   input  logic [REG_W-1:0]  cr2_wdata,
   output logic [REG_W-1:0]  cr1_rdata,
   output logic [REG_W-1:0]  cr2_rdata,
   output logic [GAIN_W-1:0] gain,
   output logic              core_run,
   output logic              run_ok,
   output logic              clk_gate_en,
   output logic              clk_mode
);
   import hm_pkg::*;

   localparam int UNITY_I    = 1 << (GAIN_W - 1);
   localparam int RAMP_TICKS = (UNITY_I + STEP - 1) / STEP;

   generate
      if (GAIN_W < 2 || GAIN_W > 30) begin : g_bad_w
         $error("halt_mute_ctrl: GAIN_W out of range");
      end
      if (STEP < 1 || STEP > UNITY_I) begin : g_bad_step
         $error("halt_mute_ctrl: STEP must be 1..unity");
      end
      if (RAMP_TICKS + 2 > MAX_STOP_TICKS) begin : g_bad_bound
         $error("halt_mute_ctrl: ramp cannot finish inside MAX_STOP_TICKS");
      end
      if (REG_W < 7) begin : g_bad_reg
         $error("halt_mute_ctrl: REG_W must hold bit 6");
      end
   endgenerate

   hm_state_e st;
   logic halt_req, pdn, at_zero, at_unity, stopped;

   assign stopped = (st == HM_HALTED);

   hm_regs #(.REG_W(REG_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cr1_we(cr1_we), .cr1_wdata(cr1_wdata),
      .cr2_we(cr2_we), .cr2_wdata(cr2_wdata),
      .stopped(stopped),
      .halt_req(halt_req), .pdn(pdn), .mode(clk_mode),
      .cr1_rdata(cr1_rdata), .cr2_rdata(cr2_rdata)
   );

   hm_ramp #(.GAIN_W(GAIN_W), .STEP(STEP)) u_ramp (
      .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick),
      .go_down(st == HM_FALL), .go_up(st == HM_RISE),
      .gain(gain), .at_zero(at_zero), .at_unity(at_unity)
   );

   hm_seq u_seq (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req),
      .at_zero(at_zero), .at_unity(at_unity), .st(st)
   );

   assign core_run    = !stopped;
   assign run_ok      = (st == HM_RUN);
   assign clk_gate_en = !pdn;
endmodule

// File: rtl/halt_mute_ctrl_chk.sv
module halt_mute_ctrl_chk #(
   parameter int GAIN_W         = 16,
   parameter int STEP           = 4096,
   parameter int MAX_STOP_TICKS = 960,
   parameter int REG_W          = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fs_tick,
   input logic              cr1_we,
   input logic [REG_W-1:0]  cr1_wdata,
   input logic              cr2_we,
   input logic [REG_W-1:0]  cr1_rdata,
   input logic [GAIN_W-1:0] gain,
   input logic              core_run,
   input logic              run_ok,
   input logic              clk_gate_en,
   input logic              clk_mode
);
   localparam logic [GAIN_W-1:0] UNITY_G = GAIN_W'(1) << (GAIN_W - 1);
   localparam int LIMIT = ((1 << (GAIN_W - 1)) + STEP - 1) / STEP + 2;

   int tick_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         tick_cnt <= 0;
      else if (!cr1_rdata[0] || cr1_rdata[1]) tick_cnt <= 0;
      else if (fs_tick)                   tick_cnt <= tick_cnt + 1;
   end

   // R3
   stop_gain_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !core_run |-> (gain == '0 && cr1_rdata[1]));
   // R10
   runok_unity_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_ok |-> (gain == UNITY_G && core_run));
   // R6
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_tick |=> $stable(gain));
   // R9
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cr2_we && !cr1_rdata[6] && !cr1_rdata[1]) |=> $stable(clk_mode));
   // R8
   gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr1_we |=> (clk_gate_en == !$past(cr1_wdata[6])));
   // R7
   stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_cnt <= LIMIT);
   // R2
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fs_tick |=> ($past(gain) - gain <= GAIN_W'(STEP) || gain - $past(gain) <= GAIN_W'(STEP)));
endmodule

bind halt_mute_ctrl halt_mute_ctrl_chk #(
   .GAIN_W(GAIN_W), .STEP(STEP), .MAX_STOP_TICKS(MAX_STOP_TICKS), .REG_W(REG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick), .cr1_we(cr1_we),
   .cr1_wdata(cr1_wdata), .cr2_we(cr2_we), .cr1_rdata(cr1_rdata),
   .gain(gain), .core_run(core_run), .run_ok(run_ok),
   .clk_gate_en(clk_gate_en), .clk_mode(clk_mode)
);

// File: tb/halt_mute_ctrl_test.sv
module halt_mute_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fs_tick = 1'b0;
   logic cr1_we = 1'b0, cr2_we = 1'b0;
   logic [7:0] cr1_wdata = '0, cr2_wdata = '0;
   logic [7:0] cr1_rdata, cr2_rdata;
   logic [15:0] gain;
   logic core_run, run_ok, clk_gate_en, clk_mode;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   halt_mute_ctrl uut (
      .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick),
      .cr1_we(cr1_we), .cr1_wdata(cr1_wdata),
      .cr2_we(cr2_we), .cr2_wdata(cr2_wdata),
      .cr1_rdata(cr1_rdata), .cr2_rdata(cr2_rdata),
      .gain(gain), .core_run(core_run), .run_ok(run_ok),
      .clk_gate_en(clk_gate_en), .clk_mode(clk_mode)
   );

   // row: cr1 write value, tick edges, expected gain, core_run, stopped, run_ok
   typedef struct packed {
      logic [7:0]  wr;
      logic [7:0]  ticks;
      logic [15:0] g;
      logic        run;
      logic        stp;
      logic        ok;
   } row_t;

   localparam row_t VEC [9] = '{
      '{8'h01, 8'd4,  16'd20480, 1'b1, 1'b0, 1'b0},  // R2 partial fall
      '{8'h00, 8'd2,  16'd20480, 1'b1, 1'b0, 1'b0},  // R5 fall reversed
      '{8'h00, 8'd20, 16'd32768, 1'b1, 1'b0, 1'b1},  // R4 back to unity
      '{8'h01, 8'd12, 16'd0,     1'b0, 1'b1, 1'b0},  // R3 stopped
      '{8'h01, 8'd3,  16'd0,     1'b0, 1'b1, 1'b0},  // R3 stays stopped
      '{8'h00, 8'd1,  16'd0,     1'b1, 1'b0, 1'b0},  // R4 restart first
      '{8'h00, 8'd3,  16'd12288, 1'b1, 1'b0, 1'b0},  // R4 rising
      '{8'h01, 8'd2,  16'd12288, 1'b1, 1'b0, 1'b0},  // R5 rise reversed
      '{8'h00, 8'd12, 16'd32768, 1'b1, 1'b0, 1'b1}   // R10 normal again
   };

   task automatic chk(input string req, input int act, input int exp_v);
      total++;
      if (act !== exp_v) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic wr1(input logic [7:0] d);
      @(negedge clk); cr1_we = 1'b1; cr1_wdata = d;
      @(negedge clk); cr1_we = 1'b0;
   endtask

   task automatic wr2(input logic [7:0] d);
      @(negedge clk); cr2_we = 1'b1; cr2_wdata = d;
      @(negedge clk); cr2_we = 1'b0;
   endtask

   task automatic tick(input int n);
      fs_tick = 1'b1;
      repeat (n) @(negedge clk);
      fs_tick = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 gain", gain, 32768);
      chk("R1 core_run", core_run, 1);
      chk("R1 run_ok", run_ok, 1);
      chk("R1 clk_gate_en", clk_gate_en, 1);
      chk("R1 clk_mode", clk_mode, 0);
      chk("R1 cr1_rdata", cr1_rdata, 0);

      for (int i = 0; i < 9; i++) begin
         wr1(VEC[i].wr);
         tick(int'(VEC[i].ticks));
         chk("R2/R4/R5 gain", gain, VEC[i].g);
         chk("R3/R4 core_run", core_run, VEC[i].run);
         chk("R3 stopped", cr1_rdata[1], VEC[i].stp);
         chk("R10 run_ok", run_ok, VEC[i].ok);
      end

      // R6: halt without ticks leaves gain untouched
      wr1(8'h01);
      repeat (6) @(negedge clk);
      chk("R6 gain held", gain, 32768);
      chk("R6 core_run", core_run, 1);
      wr1(8'h00);
      repeat (3) @(negedge clk);
      chk("R6 run_ok back", run_ok, 1);

      // R9 ignored while running, R8 gate
      wr2(8'h04);
      chk("R9 mode ignored", clk_mode, 0);
      chk("R9 readback", cr2_rdata[2], 0);
      wr1(8'h40);
      chk("R8 gate off", clk_gate_en, 0);
      chk("R8 readback", cr1_rdata[6], 1);
      wr2(8'h04);
      chk("R9 mode taken pdn", clk_mode, 1);
      wr1(8'h00);
      chk("R8 gate on", clk_gate_en, 1);
      chk("R9 mode kept", clk_mode, 1);

      // R7: count ticks to stop; R9 write while stopped
      begin
         int n = 0;
         wr1(8'h01);
         while (!cr1_rdata[1] && n < 50) begin
            tick(1);
            n++;
         end
         chk("R7 ticks to stop", n, 10);
      end
      wr2(8'h00);
      chk("R9 mode taken halted", clk_mode, 0);
      chk("R8 halt readback", cr1_rdata[0], 1);
      wr1(8'h00);
      tick(12);
      chk("R4 recovered", gain, 32768);
      chk("R10 run_ok end", run_ok, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule